// File: doc/BRIEF.md
# Cascadable Bidirectional Display Data Capture

This block is the input front end of one column-driver slice. After a start pulse it takes one 36-bit pixel word on every rising clock edge. The word holds six 6-bit dots, which make up two RGB pixels. Each word goes into the next six-channel slot of a line-wide data register. One slice has 70 slots, which cover 420 channels.

The fill direction is chosen by an input.
- **Upward fill:** slots fill from channel 0 toward channel 419. The start pulse arrives on the right-side pin, and the cascade pulse leaves on the left-side pin.
- **Downward fill:** slots fill from channel 419 toward channel 0, and each word is mirrored at dot level. The two start pins swap roles.

When a slice has stored its last slot, it sends a one-clock start pulse to its neighbour and then ignores data. This lets several slices share one data bus. Two controls invert the low half and the high half of each word before it is stored. A rising edge on the latch strobe drops any capture that is in progress.

Top module: `disp_col_capture`

## Requirements
- R1: While reset is low (synchronous, active low) and after it is released, the whole line register reads zero and both cascade outputs are low. No word is stored before a start has been seen.
- R2: A start is a clock edge at which the selected start input is high and was low at the previous edge. That edge stores its word in slot 0. Each following edge stores its word in the next slot, up to slot 69, so one start covers 70 words.
- R3: With `dir_right` high, dot d of the word stored in slot i goes to channel 6i+d. Channels are numbered 0 to 419 and appear in `line_data[6c+5:6c]`. Dot d is `pix_word[6d+5:6d]`, with bit 0 as the LSB.
- R4: With `dir_right` low, dot d of the word stored in slot i goes to channel 419-6i-d.
- R5: Only the start input on the selected side can start a capture. `start_l_in` has no effect when `dir_right` is high, and `start_r_in` has no effect when it is low.
- R6: If the start input stays high for several edges, only the first high edge starts a capture. Later high edges do not restart the slot sequence.
- R7: The edge that stores slot 69 makes the far-side cascade output high for exactly one clock. The far side is `start_l_out` when `dir_right` is high and `start_r_out` when it is low. The other cascade output stays low, and neither output is high during the 69 clocks before that pulse.
- R8: After slot 69, words on the following edges are ignored and the line register does not change until the next start.
- R9: An edge at which `strobe` is high and was low at the previous edge clears the capture token. That edge's word and all later words are ignored until the next start, and no cascade pulse follows.
- R10: `inv_lo` high inverts `pix_word[17:0]` (dots 0 to 2) before storage. `inv_hi` high inverts `pix_word[35:18]` (dots 3 to 5). Both controls are sampled at the same edge as the word.
- R11: Reset asserted in the middle of a line ends the capture. Words after reset is released are ignored until a new start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| dir_right | input | 1 | Fill direction: 1 fills upward from channel 0, 0 fills downward from channel 419 |
| start_r_in | input | 1 | Right-side start input, used when dir_right is 1 |
| start_l_in | input | 1 | Left-side start input, used when dir_right is 0 |
| start_r_out | output | 1 | Right-side cascade pulse, driven when dir_right is 0 |
| start_l_out | output | 1 | Left-side cascade pulse, driven when dir_right is 1 |
| pix_word | input | 36 | Six 6-bit dots; dot d is bits [6d+5:6d] |
| inv_lo | input | 1 | Invert dots 0 to 2 before storage |
| inv_hi | input | 1 | Invert dots 3 to 5 before storage |
| strobe | input | 1 | Latch strobe; its rising edge clears the token |
| line_data | output | 2520 | Stored line; channel c is bits [6c+5:6c] |

## Verification
Full lines are written in both fill directions. The words are built from the slot number, the dot number and a per-run seed, so every dot holds a different value. A wrong slot, a wrong dot order or a missing mirror then shows up as a mismatch on a named channel. The inversion tests set only the low control, then only the high control, then both. This separates a swapped half from a missing inversion. Other runs hold the start input high for three clocks, pulse the start input on the wrong side, raise the strobe after ten words, and reset in the middle of a line. These check that only the right events start the sequence or stop it. Extra words sent after the last slot, and the clocks just before and after the cascade pulse, show whether capture ends on its own and whether the handshake pulse is a single clock on the correct side.

// File: rtl/disp_cap_pkg.sv
// Package: shared defaults and index helpers for the display data capture.
// Assumes channels are numbered from 0; mirroring maps index i to total-1-i.
package disp_cap_pkg;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned DEF_DOT_W = 6;   // bits per dot
    localparam int unsigned DEF_DOTS  = 6;   // dots per input word
    localparam int unsigned DEF_SLOTS = 70;  // words per line

    // Mirror an index inside a range of the given size.
    function automatic int mirror_index(input int idx, input int total);
        return total - 1 - idx;
    endfunction
endpackage

// File: rtl/cap_sequencer.sv
// Module: start detection, capture token and cascade handshake.
// A one-hot token walks one slot per clock after a start. Two tail stages after
// the last slot mark the end of the active window. The strobe edge clears it.
// Assumes dir_right is steady during a line.
module cap_sequencer #(
    parameter int unsigned SLOTS = 70
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dir_right,
    input  logic             start_r_in,
    input  logic             start_l_in,
    input  logic             strobe,
    output logic [SLOTS-1:0] slot_we,
    output logic             start_r_out,
    output logic             start_l_out
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned TOK_W = SLOTS + 2;   // slots plus two tail stages

    logic             start_sel;
    logic             start_q;
    logic             strobe_q;
    logic             start_fire;
    logic             strobe_rise;
    logic [TOK_W-1:0] tok;
    logic             casc_q;
    logic             casc_dir_q;

    // Pick the start input on the active side and find the rising edges.
    always_comb begin
        start_sel   = dir_right ? start_r_in : start_l_in;
        start_fire  = start_sel & ~start_q;
        strobe_rise = strobe & ~strobe_q;
    end

    // Slot write enables: the strobe wins, a start writes slot 0, else follow the token.
    always_comb begin
        slot_we = tok[SLOTS-1:0];
        if (strobe_rise) begin
            slot_we = '0;
        end else if (start_fire) begin
            slot_we = SLOTS'(1);
        end
    end

    // Edge-detect history, token walk and cascade pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q    <= 1'b0;
            strobe_q   <= 1'b0;
            tok        <= '0;
            casc_q     <= 1'b0;
            casc_dir_q <= 1'b0;
        end else begin
            start_q    <= start_sel;
            strobe_q   <= strobe;
            casc_q     <= slot_we[SLOTS-1];
            casc_dir_q <= dir_right;
            if (strobe_rise) begin
                tok <= '0;
            end else if (start_fire) begin
                tok <= TOK_W'(2);
            end else begin
                tok <= {tok[TOK_W-2:0], 1'b0};
            end
        end
    end

    // Steer the cascade pulse to the side away from the start input.
    always_comb begin
        start_l_out = casc_q & casc_dir_q;
        start_r_out = casc_q & ~casc_dir_q;
    end

    // R2: at most one slot position is active at a time.
    assert_token_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok));

    // R6: a start that is still held high never writes slot 0 again.
    assert_held_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start_sel && start_q) |-> !slot_we[0]);

    // R7: the cascade pulse lasts one clock.
    assert_cascade_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        casc_q |=> !casc_q);

    // R9: a strobe edge leaves no token and no cascade pulse behind.
    assert_strobe_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_rise |=> (tok == '0 && !casc_q));
endmodule

// File: rtl/cap_polarity.sv
// Module: per-half data inversion of one input word.
// The lower DOTS/2 dots follow inv_lo and the rest follow inv_hi. Purely combinational.
module cap_polarity #(
    parameter int unsigned DOT_W = 6,
    parameter int unsigned DOTS  = 6
) (
    input  logic [DOT_W*DOTS-1:0] word_in,
    input  logic                  inv_lo,
    input  logic                  inv_hi,
    output logic [DOT_W*DOTS-1:0] word_out
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned LO_DOTS = DOTS / 2;

    // One XOR stage per dot, with the control picked by the half the dot is in.
    for (genvar d = 0; d < DOTS; d++) begin : g_dot
        if (d < LO_DOTS) begin : g_lo
            assign word_out[d*DOT_W +: DOT_W] = word_in[d*DOT_W +: DOT_W] ^ {DOT_W{inv_lo}};
        end else begin : g_hi
            assign word_out[d*DOT_W +: DOT_W] = word_in[d*DOT_W +: DOT_W] ^ {DOT_W{inv_hi}};
        end
    end
endmodule

// File: rtl/cap_line_store.sv
// Module: line-wide data register with direction-dependent slot steering.
// Each channel knows two fixed (slot, dot) pairs, one per direction, and loads
// its dot when its slot is enabled. Assumes at most one slot enable is high.
module cap_line_store
    import disp_cap_pkg::*;
#(
    parameter int unsigned DOT_W = 6,
    parameter int unsigned DOTS  = 6,
    parameter int unsigned SLOTS = 70
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dir_right,
    input  logic [DOT_W*DOTS-1:0]       word,
    input  logic [SLOTS-1:0]            slot_we,
    output logic [SLOTS*DOTS*DOT_W-1:0] line_q
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned CHANS = SLOTS * DOTS;

    for (genvar ch = 0; ch < CHANS; ch++) begin : g_chan
        localparam int UP_SLOT = ch / DOTS;
        localparam int UP_DOT  = ch % DOTS;
        localparam int DN_SLOT = mirror_index(ch, CHANS) / DOTS;
        localparam int DN_DOT  = mirror_index(ch, CHANS) % DOTS;

        logic             ch_we;
        logic [DOT_W-1:0] ch_dot;

        // Select this channel's enable and source dot for the current direction.
        always_comb begin
            ch_we  = dir_right ? slot_we[UP_SLOT] : slot_we[DN_SLOT];
            ch_dot = dir_right ? word[UP_DOT*DOT_W +: DOT_W] : word[DN_DOT*DOT_W +: DOT_W];
        end

        // Channel storage: clear on reset, load on its slot enable.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                line_q[ch*DOT_W +: DOT_W] <= '0;
            end else if (ch_we) begin
                line_q[ch*DOT_W +: DOT_W] <= ch_dot;
            end
        end
    end

    // R2: the steering never sees more than one slot enabled.
    assert_single_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(slot_we));

    // R8: with no slot enabled, the stored line does not move.
    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_we == '0) |=> $stable(line_q));
endmodule

// File: rtl/disp_col_capture.sv
// Module: top of the display data capture slice.
// Inverts each incoming word per half, steers it into the line register under the
// sequencer's one-hot token, and passes the cascade pulse to the next slice.
// Assumes inputs are synchronous to clk.
module disp_col_capture
    import disp_cap_pkg::*;
#(
    parameter int unsigned DOT_W = DEF_DOT_W,
    parameter int unsigned DOTS  = DEF_DOTS,
    parameter int unsigned SLOTS = DEF_SLOTS
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        dir_right,
    input  logic                        start_r_in,
    input  logic                        start_l_in,
    output logic                        start_r_out,
    output logic                        start_l_out,
    input  logic [DOT_W*DOTS-1:0]       pix_word,
    input  logic                        inv_lo,
    input  logic                        inv_hi,
    input  logic                        strobe,
    output logic [SLOTS*DOTS*DOT_W-1:0] line_data
);
    timeunit 1ns;
    timeprecision 100ps;

    localparam int unsigned WORD_W = DOT_W * DOTS;

    logic [WORD_W-1:0] word_pol;
    logic [SLOTS-1:0]  slot_we;

    cap_sequencer #(.SLOTS(SLOTS)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_right  (dir_right),
        .start_r_in (start_r_in),
        .start_l_in (start_l_in),
        .strobe     (strobe),
        .slot_we    (slot_we),
        .start_r_out(start_r_out),
        .start_l_out(start_l_out)
    );

    cap_polarity #(.DOT_W(DOT_W), .DOTS(DOTS)) u_pol (
        .word_in (pix_word),
        .inv_lo  (inv_lo),
        .inv_hi  (inv_hi),
        .word_out(word_pol)
    );

    cap_line_store #(.DOT_W(DOT_W), .DOTS(DOTS), .SLOTS(SLOTS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .dir_right(dir_right),
        .word     (word_pol),
        .slot_we  (slot_we),
        .line_q   (line_data)
    );

    // R7: the two cascade outputs are never high together.
    assert_cascade_one_side_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_r_out && start_l_out));
endmodule

// File: tb/tb_disp_col_capture.sv
// Directed bench for disp_col_capture: one task per scenario, each checks its own results.
module tb_disp_col_capture;
    timeunit 1ns;
    timeprecision 100ps;

    localparam int DOT_W  = 6;
    localparam int DOTS   = 6;
    localparam int SLOTS  = 70;
    localparam int CHANS  = SLOTS * DOTS;
    localparam int WORD_W = DOT_W * DOTS;
    localparam int LINE_W = CHANS * DOT_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              dir_right = 1'b1;
    logic              start_r_in = 1'b0;
    logic              start_l_in = 1'b0;
    logic              start_r_out;
    logic              start_l_out;
    logic [WORD_W-1:0] pix_word = '0;
    logic              inv_lo = 1'b0;
    logic              inv_hi = 1'b0;
    logic              strobe = 1'b0;
    logic [LINE_W-1:0] line_data;

    int         checks = 0;
    int         fails = 0;
    bit         done = 0;
    logic [5:0] exp_ch [CHANS];

    disp_col_capture dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .dir_right  (dir_right),
        .start_r_in (start_r_in),
        .start_l_in (start_l_in),
        .start_r_out(start_r_out),
        .start_l_out(start_l_out),
        .pix_word   (pix_word),
        .inv_lo     (inv_lo),
        .inv_hi     (inv_hi),
        .strobe     (strobe),
        .line_data  (line_data)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic [WORD_W-1:0] mkword(input int seed, input int k);
        logic [WORD_W-1:0] w;
        for (int d = 0; d < DOTS; d++) w[d*DOT_W +: DOT_W] = 6'(seed*13 + k*7 + d*11 + 3);
        return w;
    endfunction

    // Model of R3, R4 and R10: where each dot of a stored word lands.
    function automatic void model_store(input bit right, input int slot, input logic [WORD_W-1:0] w,
                                        input bit il, input bit ih);
        for (int d = 0; d < DOTS; d++) begin
            logic [5:0] v;
            int ch;
            v  = w[d*DOT_W +: DOT_W] ^ {6{(d < DOTS/2) ? il : ih}};
            ch = right ? slot*DOTS + d : CHANS - 1 - slot*DOTS - d;
            exp_ch[ch] = v;
        end
    endfunction

    task automatic check_line(input string req, input string what);
        int bad = 0;
        int first = -1;
        for (int ch = 0; ch < CHANS; ch++) begin
            if (line_data[ch*DOT_W +: DOT_W] !== exp_ch[ch]) begin
                bad++;
                if (first < 0) first = ch;
            end
        end
        checks++;
        if (bad != 0) begin
            fails++;
            $display("FAIL %s %s: %0d channels differ, ch %0d actual %0d expected %0d",
                     req, what, bad, first, line_data[first*DOT_W +: DOT_W], exp_ch[first]);
        end
    endtask

    task automatic set_start(input bit right, input bit v);
        start_r_in = right ? v : 1'b0;
        start_l_in = right ? 1'b0 : v;
    endtask

    // Full line: start held for 'hold' clocks, 70 words, cascade timing, then extra words.
    task automatic run_line(input bit right, input int seed, input bit il, input bit ih,
                            input int hold, input string req);
        bit early = 0;
        dir_right = right;
        inv_lo = il;
        inv_hi = ih;
        for (int k = 0; k < SLOTS; k++) begin
            @(negedge clk);
            if (k > 0 && (start_r_out || start_l_out)) early = 1;
            pix_word = mkword(seed, k);
            set_start(right, k < hold);
            model_store(right, k, pix_word, il, ih);
        end
        @(negedge clk);
        chk(!early, "R7", "no cascade before last slot", int'(early), 0);
        chk((right ? start_l_out : start_r_out) == 1'b1, "R7", "far-side pulse high",
            int'(right ? start_l_out : start_r_out), 1);
        chk((right ? start_r_out : start_l_out) == 1'b0, "R7", "near side stays low",
            int'(right ? start_r_out : start_l_out), 0);
        set_start(right, 1'b0);
        pix_word = ~mkword(seed, 0);
        @(negedge clk);
        chk(!start_r_out && !start_l_out, "R7", "pulse lasts one clock",
            int'(start_r_out) + int'(start_l_out), 0);
        check_line(req, "line contents after fill (R2 slot order)");
        for (int k = 0; k < 4; k++) begin
            pix_word = mkword(seed + 99, k);
            @(negedge clk);
        end
        check_line("R8", "words after last slot ignored");
    endtask

    task automatic t_reset_state();
        for (int ch = 0; ch < CHANS; ch++) exp_ch[ch] = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check_line("R1", "line cleared in reset");
        chk(!start_r_out && !start_l_out, "R1", "cascade low in reset",
            int'(start_r_out) + int'(start_l_out), 0);
        rst_n = 1'b1;
        for (int k = 0; k < 5; k++) begin
            pix_word = mkword(7, k);
            @(negedge clk);
        end
        check_line("R1", "no storage before start");
    endtask

    task automatic t_wrong_side();
        bit seen = 0;
        dir_right = 1'b1;
        for (int k = 0; k < SLOTS + 3; k++) begin
            @(negedge clk);
            if (start_r_out || start_l_out) seen = 1;
            pix_word = mkword(31, k);
            start_r_in = 1'b0;
            start_l_in = (k == 0);
        end
        @(negedge clk);
        start_l_in = 1'b0;
        check_line("R5", "inactive-side start ignored");
        chk(!seen, "R5", "no cascade from inactive start", int'(seen), 0);
    endtask

    task automatic t_strobe_abort();
        bit seen = 0;
        dir_right = 1'b1;
        inv_lo = 1'b0;
        inv_hi = 1'b0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            pix_word = mkword(41, k);
            set_start(1'b1, k == 0);
            model_store(1'b1, k, pix_word, 1'b0, 1'b0);
        end
        @(negedge clk);
        set_start(1'b1, 1'b0);
        strobe = 1'b1;
        pix_word = mkword(41, 10);
        for (int k = 11; k < SLOTS + 4; k++) begin
            @(negedge clk);
            if (start_r_out || start_l_out) seen = 1;
            if (k == 13) strobe = 1'b0;
            pix_word = mkword(41, k);
        end
        @(negedge clk);
        check_line("R9", "strobe edge stops capture");
        chk(!seen, "R9", "no cascade after strobe", int'(seen), 0);
    endtask

    task automatic t_reset_mid();
        bit seen = 0;
        dir_right = 1'b0;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk);
            pix_word = mkword(55, k);
            set_start(1'b0, k == 0);
        end
        @(negedge clk);
        set_start(1'b0, 1'b0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        for (int ch = 0; ch < CHANS; ch++) exp_ch[ch] = '0;
        for (int k = 0; k < SLOTS + 3; k++) begin
            pix_word = mkword(56, k);
            @(negedge clk);
            if (start_r_out || start_l_out) seen = 1;
        end
        check_line("R11", "capture ended by reset");
        chk(!seen, "R11", "no cascade after reset", int'(seen), 0);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        t_reset_state();
        run_line(1'b1, 1, 1'b0, 1'b0, 1, "R3");   // R2 and R3: upward fill
        run_line(1'b0, 2, 1'b0, 1'b0, 1, "R4");   // R4: downward, mirrored fill
        run_line(1'b1, 3, 1'b1, 1'b0, 1, "R10");  // R10: low half only
        run_line(1'b0, 4, 1'b0, 1'b1, 1, "R10");  // R10: high half only
        run_line(1'b1, 5, 1'b1, 1'b1, 1, "R10");  // R10: both halves
        run_line(1'b1, 6, 1'b0, 1'b0, 3, "R6");   // R6: start held three clocks
        t_wrong_side();
        t_strobe_abort();
        t_reset_mid();
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            finish_run();
        end
    end
endmodule